// File: doc/BRIEF.md
# Conversion Mode and Calibration Sequencer

This block is the control state machine that walks a sigma-delta converter through its operating modes. A 3-bit mode word, written with a one-cycle strobe, selects one of these: a free-running conversion stream, a one-shot conversion, idle, power-down, or one of four calibrations. The sequencer counts conversion-period ticks to decide when a result or a calibration coefficient is due. It keeps the ready and error flags, clamps faulty results, and stores each calibration coefficient into the offset or full-scale slot of the selected channel. The modulator and the decimation filter sit outside the block. The filter supplies `filt_data` and the fault inputs, which the sequencer samples on the tick that completes a period.

The states are ST_SETTLE (first result of a stream pending), ST_STREAM (stream running), ST_SINGLE (one-shot pending), ST_CAL (calibration pending), ST_IDLE and ST_PDN. These are the transitions. A mode write always wins: continuous goes to ST_SETTLE, single to ST_SINGLE, idle to ST_IDLE, power-down to ST_PDN, a legal calibration to ST_CAL, and a refused calibration to ST_IDLE. When the tick counter reports a period complete, ST_SETTLE moves to ST_STREAM, ST_SINGLE moves to ST_PDN, and ST_CAL moves to ST_IDLE. ST_STREAM stays where it is and emits a result on every tick. ST_IDLE and ST_PDN ignore ticks. After reset the block is in ST_SETTLE with mode 000.

Top module: `convseq_top`

## Requirements
- R1: After reset, rdy=0, err=0, result=0, mode_now=000 and psw_on=1. Every channel slot reads offset 0x800000 and full-scale 0x5A3C65.
- R2: After a mode write of 000, the first result (rdy rises and result takes filt_data) arrives on the 2nd conv_tick when chop_off=0, and on the 1st when chop_off=1.
- R3: Once the stream has settled, every further conv_tick delivers a new result with rdy=1, whether or not the previous result was read.
- R4: Mode 001 delivers one result after the same settling count as R2. It then sets rdy=1, mode_now becomes 011 and psw_on drops to 0. The result and rdy are held until res_read or the next mode write.
- R5: A res_read pulse clears rdy and leaves result unchanged.
- R6: In the settled stream, an upd_warn pulse clears an unread rdy.
- R7: Any mode write clears rdy and restarts the tick count. A write of 011 also drives psw_on to 0; psw_on is 1 in every other state.
- R8: Calibration length in ticks. Modes 100 (internal zero), 110 (system offset) and 111 (system full-scale) take 2 ticks with chop_off=0 and 1 tick with chop_off=1. Mode 101 (internal full-scale) takes the same at gain code 000, and twice that at any other gain code.
- R9: When a calibration ends, rdy=1 and mode_now=010. filt_data from the final tick is written to the offset slot (modes 100/110) or the full-scale slot (101/111) of the channel. Channel codes 0, 1 and 2 each own a slot; codes 3 and above share one slot.
- R10: Mode 101 with gain code 111 is refused. The block goes straight to mode_now=010 with err=1, and both coefficients stay unchanged.
- R11: A result sampled with udr_flag=1 is clamped to 0x000000. One sampled with ovr_flag=1 or ref_miss=1 (and udr_flag=0) is clamped to 0xFFFFFF. In both cases err=1 rises together with rdy. A clean result clears err, and so does a mode write of 000, 001 or 1xx.
- R12: A host coefficient write (coef_wr, with coef_sel_fs choosing the full-scale slot when 1) is accepted only in idle or power-down. It is ignored in every other state.
- R13: In idle and power-down the tick count is held at zero, and ticks change neither rdy nor result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode word written by mode_wr |
| chop_off | input | 1 | 1 = chopping disabled |
| gain_code | input | 3 | Gain code, 000 = unity, 111 = top gain |
| chan_code | input | 3 | Selected channel |
| conv_tick | input | 1 | End of one conversion period |
| upd_warn | input | 1 | Next output update is imminent |
| filt_data | input | 24 | Filter output, valid with conv_tick |
| ovr_flag | input | 1 | Over-range on the current sample |
| udr_flag | input | 1 | Under-range on the current sample |
| ref_miss | input | 1 | Reference missing on the current sample |
| res_read | input | 1 | Host has read the result |
| coef_wr | input | 1 | Host coefficient write strobe |
| coef_sel_fs | input | 1 | Host write target: 1 = full-scale, 0 = offset |
| coef_wdata | input | 24 | Host coefficient value |
| rdy | output | 1 | Result or calibration ready |
| err | output | 1 | Error flag |
| result | output | 24 | Latest conversion result |
| mode_now | output | 3 | Effective mode word |
| psw_on | output | 1 | Low-side power switch closed |
| ofs_coef | output | 24 | Offset coefficient of the selected channel |
| fs_coef | output | 24 | Full-scale coefficient of the selected channel |

## Verification
Every output is registered once. The effect of a strobe or tick driven during one cycle is visible just after the next rising edge, and the selected coefficients follow chan_code with no delay. The bench drives each stimulus for exactly one cycle starting at a falling edge, then samples at the following falling edge. Each expected item (rdy, err, result, mode_now, psw_on) is pushed into the scoreboard for that instant. Settling and calibration lengths are checked by sampling after every intermediate tick, so a result that arrives one tick early or late is caught.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    typedef enum logic [2:0] {
        M_CONT   = 3'b000,
        M_SINGLE = 3'b001,
        M_IDLE   = 3'b010,
        M_PDN    = 3'b011,
        M_ZCAL   = 3'b100,
        M_FCAL   = 3'b101,
        M_SOCAL  = 3'b110,
        M_SFCAL  = 3'b111
    } mode_e;

    typedef enum logic [2:0] {
        ST_PDN,
        ST_IDLE,
        ST_SETTLE,
        ST_STREAM,
        ST_SINGLE,
        ST_CAL
    } state_e;

    typedef enum logic [1:0] {
        LEN_FIRST,
        LEN_NEXT,
        LEN_CAL,
        LEN_CAL_IFS
    } len_e;

    localparam logic [2:0] GAIN_UNITY = 3'b000;
    localparam logic [2:0] GAIN_TOP   = 3'b111;

endpackage

// File: rtl/convseq_timer.sv
module convseq_timer
    import convseq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic       tick,
    input  len_e       len_kind,
    input  logic       chop_off,
    input  logic [2:0] gain_code,
    output logic       due
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] need;

    always_comb begin
        base_len = chop_off ? CNT_W'(1) : CNT_W'(2);
        unique case (len_kind)
            LEN_NEXT:    need = CNT_W'(1);
            LEN_CAL_IFS: need = (gain_code == GAIN_UNITY) ? base_len : CNT_W'(base_len << 1);
            default:     need = base_len;
        endcase
    end

    assign due = run && !restart && tick && (cnt_q == need - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart || due) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R13: count held at zero while not running
    p_cnt_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

    // R3: a completed period restarts the count
    p_due_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        due |=> (cnt_q == '0));

endmodule

// File: rtl/convseq_coefbank.sv
module convseq_coefbank #(
    parameter int          W       = 24,
    parameter int          CH_W    = 3,
    parameter int          N_OWN   = 3,
    parameter logic [23:0] OFS_RST = 24'h800000,
    parameter logic [23:0] FS_RST  = 24'h5A3C65
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_fs,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [W-1:0]    wr_data,
    input  logic [CH_W-1:0] rd_chan,
    output logic [W-1:0]    ofs_o,
    output logic [W-1:0]    fs_o
);

    localparam int N_SLOT = N_OWN + 1;
    localparam int SLOT_W = $clog2(N_SLOT);

    function automatic logic [SLOT_W-1:0] slot_of(input logic [CH_W-1:0] c);
        if (int'(c) < N_OWN) return SLOT_W'(c);
        return SLOT_W'(N_OWN);
    endfunction

    logic [W-1:0]      ofs_q [N_SLOT];
    logic [W-1:0]      fs_q  [N_SLOT];
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] rd_slot;

    assign wr_slot = slot_of(wr_chan);
    assign rd_slot = slot_of(rd_chan);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) begin
                ofs_q[i] <= W'(OFS_RST);
                fs_q[i]  <= W'(FS_RST);
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_SLOT; i++) begin
                if (wr_slot == SLOT_W'(i)) begin
                    if (wr_fs) fs_q[i]  <= wr_data;
                    else       ofs_q[i] <= wr_data;
                end
            end
        end
    end

    assign ofs_o = ofs_q[rd_slot];
    assign fs_o  = fs_q[rd_slot];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot_chk
        // R12: a slot moves only when written
        p_slot_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_slot == SLOT_W'(g)) |=> ($stable(ofs_q[g]) && $stable(fs_q[g])));
    end

endmodule

// File: rtl/convseq_ctrl.sv
module convseq_ctrl
    import convseq_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic [2:0]   mode_in,
    input  logic [2:0]   gain_code,
    input  logic [W-1:0] filt_data,
    input  logic         ovr_flag,
    input  logic         udr_flag,
    input  logic         ref_miss,
    input  logic         res_read,
    input  logic         upd_warn,
    input  logic         host_wr,
    input  logic         host_sel_fs,
    input  logic [W-1:0] host_data,
    input  logic         due,
    output logic         run,
    output logic         restart,
    output len_e         len_kind,
    output logic         cwr,
    output logic         csel_fs,
    output logic [W-1:0] cdata,
    output logic         rdy,
    output logic         err,
    output logic [W-1:0] result,
    output logic [2:0]   mode_now,
    output logic         psw_on
);

    state_e       st_q, st_d;
    mode_e        mode_q, mode_d;
    mode_e        mode_req;
    logic         rdy_q, err_q;
    logic [W-1:0] result_q;
    logic         illegal_cal;
    logic         cal_done;
    logic         conv_done;
    logic         fault;
    logic [W-1:0] clamped;

    assign mode_req    = mode_e'(mode_in);
    assign illegal_cal = (mode_req == M_FCAL) && (gain_code == GAIN_TOP);
    assign cal_done    = due && (st_q == ST_CAL);
    assign conv_done   = due && (st_q == ST_SETTLE || st_q == ST_STREAM || st_q == ST_SINGLE);
    assign fault       = udr_flag || ovr_flag || ref_miss;

    always_comb begin
        if (udr_flag)                  clamped = '0;
        else if (ovr_flag || ref_miss) clamped = '1;
        else                           clamped = filt_data;
    end

    // next-state logic
    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        if (mode_wr) begin
            mode_d = mode_req;
            unique case (mode_req)
                M_CONT:   st_d = ST_SETTLE;
                M_SINGLE: st_d = ST_SINGLE;
                M_IDLE:   st_d = ST_IDLE;
                M_PDN:    st_d = ST_PDN;
                default: begin
                    if (illegal_cal) begin
                        st_d   = ST_IDLE;
                        mode_d = M_IDLE;
                    end else begin
                        st_d = ST_CAL;
                    end
                end
            endcase
        end else if (due) begin
            unique case (st_q)
                ST_SETTLE: st_d = ST_STREAM;
                ST_SINGLE: begin
                    st_d   = ST_PDN;
                    mode_d = M_PDN;
                end
                ST_CAL: begin
                    st_d   = ST_IDLE;
                    mode_d = M_IDLE;
                end
                default: st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_SETTLE;
            mode_q <= M_CONT;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
        end
    end

    // status and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q    <= 1'b0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else if (mode_wr) begin
            rdy_q <= 1'b0;
            if (illegal_cal)
                err_q <= 1'b1;
            else if (mode_req != M_IDLE && mode_req != M_PDN)
                err_q <= 1'b0;
        end else if (conv_done) begin
            result_q <= clamped;
            rdy_q    <= 1'b1;
            err_q    <= fault;
        end else if (cal_done) begin
            rdy_q <= 1'b1;
        end else if (res_read) begin
            rdy_q <= 1'b0;
        end else if (upd_warn && st_q == ST_STREAM) begin
            rdy_q <= 1'b0;
        end
    end

    // timer control
    always_comb begin
        run     = (st_q == ST_SETTLE) || (st_q == ST_STREAM) ||
                  (st_q == ST_SINGLE) || (st_q == ST_CAL);
        restart = mode_wr;
        unique case (st_q)
            ST_STREAM: len_kind = LEN_NEXT;
            ST_CAL:    len_kind = (mode_q == M_FCAL) ? LEN_CAL_IFS : LEN_CAL;
            default:   len_kind = LEN_FIRST;
        endcase
    end

    // coefficient write routing
    always_comb begin
        if (cal_done) begin
            cwr     = 1'b1;
            csel_fs = (mode_q == M_FCAL) || (mode_q == M_SFCAL);
            cdata   = filt_data;
        end else begin
            cwr     = host_wr && (st_q == ST_IDLE || st_q == ST_PDN);
            csel_fs = host_sel_fs;
            cdata   = host_data;
        end
    end

    assign rdy      = rdy_q;
    assign err      = err_q;
    assign result   = result_q;
    assign mode_now = mode_q;
    assign psw_on   = (st_q != ST_PDN);

    // R7: a mode write clears ready
    p_wr_drops_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !rdy_q);

    // R7: power-down write opens the switch
    p_pdn_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_req == M_PDN) |=> !psw_on);

    // R4: one-shot result returns to power-down with ready held
    p_single_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (due && st_q == ST_SINGLE && !mode_wr) |=> (mode_q == M_PDN && rdy_q));

    // R9: every calibration ends in idle with ready
    p_cal_ends_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !mode_wr) |=> (mode_q == M_IDLE && rdy_q));

    // R10: refused calibration goes to idle with error
    p_illegal_ifs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && illegal_cal) |=> (mode_q == M_IDLE && err_q && !rdy_q));

    // R13: no new result while idle or powered down
    p_no_result_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE || st_q == ST_PDN) && !mode_wr) |=> $stable(result_q));

endmodule

// File: rtl/convseq_top.sv
module convseq_top
    import convseq_pkg::*;
#(
    parameter int          DATA_W  = 24,
    parameter int          CH_W    = 3,
    parameter int          N_OWN   = 3,
    parameter int          CNT_W   = 3,
    parameter logic [23:0] OFS_RST = 24'h800000,
    parameter logic [23:0] FS_RST  = 24'h5A3C65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [2:0]        mode_in,
    input  logic              chop_off,
    input  logic [2:0]        gain_code,
    input  logic [CH_W-1:0]   chan_code,
    input  logic              conv_tick,
    input  logic              upd_warn,
    input  logic [DATA_W-1:0] filt_data,
    input  logic              ovr_flag,
    input  logic              udr_flag,
    input  logic              ref_miss,
    input  logic              res_read,
    input  logic              coef_wr,
    input  logic              coef_sel_fs,
    input  logic [DATA_W-1:0] coef_wdata,
    output logic              rdy,
    output logic              err,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        mode_now,
    output logic              psw_on,
    output logic [DATA_W-1:0] ofs_coef,
    output logic [DATA_W-1:0] fs_coef
);

    logic              due;
    logic              run;
    logic              restart;
    len_e              len_kind;
    logic              cwr;
    logic              csel_fs;
    logic [DATA_W-1:0] cdata;

    convseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (restart),
        .tick      (conv_tick),
        .len_kind  (len_kind),
        .chop_off  (chop_off),
        .gain_code (gain_code),
        .due       (due)
    );

    convseq_ctrl #(.W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wr     (mode_wr),
        .mode_in     (mode_in),
        .gain_code   (gain_code),
        .filt_data   (filt_data),
        .ovr_flag    (ovr_flag),
        .udr_flag    (udr_flag),
        .ref_miss    (ref_miss),
        .res_read    (res_read),
        .upd_warn    (upd_warn),
        .host_wr     (coef_wr),
        .host_sel_fs (coef_sel_fs),
        .host_data   (coef_wdata),
        .due         (due),
        .run         (run),
        .restart     (restart),
        .len_kind    (len_kind),
        .cwr         (cwr),
        .csel_fs     (csel_fs),
        .cdata       (cdata),
        .rdy         (rdy),
        .err         (err),
        .result      (result),
        .mode_now    (mode_now),
        .psw_on      (psw_on)
    );

    convseq_coefbank #(
        .W       (DATA_W),
        .CH_W    (CH_W),
        .N_OWN   (N_OWN),
        .OFS_RST (OFS_RST),
        .FS_RST  (FS_RST)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cwr),
        .wr_fs   (csel_fs),
        .wr_chan (chan_code),
        .wr_data (cdata),
        .rd_chan (chan_code),
        .ofs_o   (ofs_coef),
        .fs_o    (fs_coef)
    );

endmodule

// File: tb/convseq_tb.sv
module convseq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_in = 3'b000;
    logic        chop_off = 1'b0;
    logic [2:0]  gain_code = 3'b000;
    logic [2:0]  chan_code = 3'b000;
    logic        conv_tick = 1'b0;
    logic        upd_warn = 1'b0;
    logic [23:0] filt_data = 24'h0;
    logic        ovr_flag = 1'b0;
    logic        udr_flag = 1'b0;
    logic        ref_miss = 1'b0;
    logic        res_read = 1'b0;
    logic        coef_wr = 1'b0;
    logic        coef_sel_fs = 1'b0;
    logic [23:0] coef_wdata = 24'h0;
    logic        rdy, err, psw_on;
    logic [23:0] result, ofs_coef, fs_coef;
    logic [2:0]  mode_now;

    localparam logic [23:0] OFS_DEF = 24'h800000;
    localparam logic [23:0] FS_DEF  = 24'h5A3C65;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    convseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .chop_off(chop_off), .gain_code(gain_code), .chan_code(chan_code),
        .conv_tick(conv_tick), .upd_warn(upd_warn), .filt_data(filt_data),
        .ovr_flag(ovr_flag), .udr_flag(udr_flag), .ref_miss(ref_miss),
        .res_read(res_read), .coef_wr(coef_wr), .coef_sel_fs(coef_sel_fs),
        .coef_wdata(coef_wdata), .rdy(rdy), .err(err), .result(result),
        .mode_now(mode_now), .psw_on(psw_on), .ofs_coef(ofs_coef), .fs_coef(fs_coef)
    );

    typedef struct {
        string       req;
        logic        r;
        logic        e;
        logic [23:0] res;
        logic [2:0]  m;
        logic        p;
    } exp_t;

    exp_t sb_q[$];
    event sb_ev;

    task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk(it.req, "rdy", 24'(rdy), 24'(it.r));
                chk(it.req, "err", 24'(err), 24'(it.e));
                chk(it.req, "result", result, it.res);
                chk(it.req, "mode_now", 24'(mode_now), 24'(it.m));
                chk(it.req, "psw_on", 24'(psw_on), 24'(it.p));
            end
        end
    end

    task automatic expect_st(input string req, input logic r, input logic e,
                             input logic [23:0] res, input logic [2:0] m, input logic p);
        exp_t it;
        it.req = req; it.r = r; it.e = e; it.res = res; it.m = m; it.p = p;
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic wr_mode(input logic [2:0] m);
        mode_in = m; mode_wr = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic tick(input logic [23:0] d);
        filt_data = d; conv_tick = 1'b1;
        @(negedge clk); conv_tick = 1'b0;
    endtask

    task automatic read_res();
        res_read = 1'b1;
        @(negedge clk); res_read = 1'b0;
    endtask

    task automatic warn();
        upd_warn = 1'b1;
        @(negedge clk); upd_warn = 1'b0;
    endtask

    task automatic host_coef(input logic fs, input logic [23:0] d);
        coef_sel_fs = fs; coef_wdata = d; coef_wr = 1'b1;
        @(negedge clk); coef_wr = 1'b0;
    endtask

    task automatic finish_run();
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_st("R1", 0, 0, 24'h0, 3'b000, 1);
        chk("R1", "ofs_coef", ofs_coef, OFS_DEF);
        chk("R1", "fs_coef", fs_coef, FS_DEF);

        // R2/R3/R5/R6 chop on
        wr_mode(3'b000);
        expect_st("R7", 0, 0, 24'h0, 3'b000, 1);
        tick(24'h0A0A0A);
        expect_st("R2", 0, 0, 24'h0, 3'b000, 1);
        tick(24'h0A0A0A);
        expect_st("R2", 1, 0, 24'h0A0A0A, 3'b000, 1);
        tick(24'h0B0B0B);
        expect_st("R3", 1, 0, 24'h0B0B0B, 3'b000, 1);
        read_res();
        expect_st("R5", 0, 0, 24'h0B0B0B, 3'b000, 1);
        tick(24'h0C0C0C);
        expect_st("R3", 1, 0, 24'h0C0C0C, 3'b000, 1);
        warn();
        expect_st("R6", 0, 0, 24'h0C0C0C, 3'b000, 1);

        // R2 chop off
        chop_off = 1'b1;
        wr_mode(3'b000);
        expect_st("R7", 0, 0, 24'h0C0C0C, 3'b000, 1);
        tick(24'h0D0D0D);
        expect_st("R2", 1, 0, 24'h0D0D0D, 3'b000, 1);

        // R11 clamping and error
        ovr_flag = 1'b1;
        tick(24'h123456);
        expect_st("R11", 1, 1, 24'hFFFFFF, 3'b000, 1);
        ovr_flag = 1'b0; udr_flag = 1'b1;
        tick(24'h123456);
        expect_st("R11", 1, 1, 24'h000000, 3'b000, 1);
        udr_flag = 1'b0; ref_miss = 1'b1;
        tick(24'h123456);
        expect_st("R11", 1, 1, 24'hFFFFFF, 3'b000, 1);
        ref_miss = 1'b0;
        wr_mode(3'b000);
        expect_st("R11", 0, 0, 24'hFFFFFF, 3'b000, 1);
        tick(24'h0E0E0E);
        expect_st("R11", 1, 0, 24'h0E0E0E, 3'b000, 1);

        // R4 single conversion
        chop_off = 1'b0;
        wr_mode(3'b001);
        expect_st("R4", 0, 0, 24'h0E0E0E, 3'b001, 1);
        tick(24'h1F1F1F);
        expect_st("R4", 0, 0, 24'h0E0E0E, 3'b001, 1);
        tick(24'h1F1F1F);
        expect_st("R4", 1, 0, 24'h1F1F1F, 3'b011, 0);
        tick(24'h2A2A2A);
        expect_st("R13", 1, 0, 24'h1F1F1F, 3'b011, 0);
        read_res();
        expect_st("R5", 0, 0, 24'h1F1F1F, 3'b011, 0);

        // R7 power-down write
        wr_mode(3'b000);
        expect_st("R7", 0, 0, 24'h1F1F1F, 3'b000, 1);
        tick(24'h2B2B2B);
        tick(24'h2B2B2B);
        expect_st("R2", 1, 0, 24'h2B2B2B, 3'b000, 1);
        wr_mode(3'b011);
        expect_st("R7", 0, 0, 24'h2B2B2B, 3'b011, 0);
        tick(24'h2C2C2C);
        expect_st("R13", 0, 0, 24'h2B2B2B, 3'b011, 0);

        // R13 idle
        wr_mode(3'b010);
        expect_st("R13", 0, 0, 24'h2B2B2B, 3'b010, 1);
        tick(24'h2D2D2D);
        tick(24'h2D2D2D);
        expect_st("R13", 0, 0, 24'h2B2B2B, 3'b010, 1);

        // R12 host coefficient writes
        chan_code = 3'd1;
        host_coef(1'b0, 24'h111111);
        chk("R12", "ofs_coef idle write", ofs_coef, 24'h111111);
        host_coef(1'b1, 24'h333333);
        chk("R12", "fs_coef idle write", fs_coef, 24'h333333);
        wr_mode(3'b000);
        host_coef(1'b0, 24'h222222);
        chk("R12", "ofs_coef write while converting", ofs_coef, 24'h111111);
        wr_mode(3'b010);

        // R10 refused internal full-scale at top gain
        gain_code = 3'b111;
        wr_mode(3'b101);
        expect_st("R10", 0, 1, 24'h2B2B2B, 3'b010, 1);
        tick(24'h3A3A3A);
        tick(24'h3A3A3A);
        expect_st("R10", 0, 1, 24'h2B2B2B, 3'b010, 1);
        chk("R10", "fs_coef unchanged", fs_coef, 24'h333333);
        chk("R10", "ofs_coef unchanged", ofs_coef, 24'h111111);

        // R8/R9 internal zero-scale, shared slot
        gain_code = 3'b000; chan_code = 3'd3;
        wr_mode(3'b100);
        expect_st("R8", 0, 0, 24'h2B2B2B, 3'b100, 1);
        tick(24'h4C4C4C);
        expect_st("R8", 0, 0, 24'h2B2B2B, 3'b100, 1);
        tick(24'h4D4D4D);
        expect_st("R9", 1, 0, 24'h2B2B2B, 3'b010, 1);
        chk("R9", "ofs_coef chan3", ofs_coef, 24'h4D4D4D);
        chan_code = 3'd5; #1;
        chk("R9", "ofs_coef chan5 shares slot", ofs_coef, 24'h4D4D4D);
        chan_code = 3'd0; #1;
        chk("R9", "ofs_coef chan0 own slot", ofs_coef, OFS_DEF);

        // R8 internal full-scale, gain 3, chop on: 4 ticks
        gain_code = 3'b011; chan_code = 3'd2;
        wr_mode(3'b101);
        for (int k = 0; k < 3; k++) tick(24'h5E5E5E);
        expect_st("R8", 0, 0, 24'h2B2B2B, 3'b101, 1);
        tick(24'h5F5F5F);
        expect_st("R8", 1, 0, 24'h2B2B2B, 3'b010, 1);
        chk("R9", "fs_coef chan2", fs_coef, 24'h5F5F5F);

        // R8 internal full-scale, unity gain, chop off: 1 tick
        gain_code = 3'b000; chop_off = 1'b1;
        wr_mode(3'b101);
        tick(24'h606060);
        expect_st("R8", 1, 0, 24'h2B2B2B, 3'b010, 1);
        chk("R9", "fs_coef chan2 unity", fs_coef, 24'h606060);

        // R8 internal full-scale, gain 3, chop off: 2 ticks
        gain_code = 3'b011;
        wr_mode(3'b101);
        tick(24'h616161);
        expect_st("R8", 0, 0, 24'h2B2B2B, 3'b101, 1);
        tick(24'h626262);
        expect_st("R8", 1, 0, 24'h2B2B2B, 3'b010, 1);
        chk("R9", "fs_coef chan2 gain3", fs_coef, 24'h626262);

        // R8/R9 system full-scale chop off, system offset chop on
        gain_code = 3'b000; chan_code = 3'd0;
        wr_mode(3'b111);
        tick(24'h707070);
        expect_st("R8", 1, 0, 24'h2B2B2B, 3'b010, 1);
        chk("R9", "fs_coef chan0 system", fs_coef, 24'h707070);
        chop_off = 1'b0;
        wr_mode(3'b110);
        tick(24'h717171);
        expect_st("R8", 0, 0, 24'h2B2B2B, 3'b110, 1);
        tick(24'h727272);
        expect_st("R8", 1, 0, 24'h2B2B2B, 3'b010, 1);
        chk("R9", "ofs_coef chan0 system", ofs_coef, 24'h727272);

        @(negedge clk);
        finish_run();
    end

endmodule